// File: doc/BRIEF.md
# Zone Write Protection Filter

This block stands between a command decoder and the byte array of a user zone and decides, for every write request, which bytes reach storage and with what value. Each request carries a start address, a byte count, up to sixteen bytes of new data and the protection mode that applies to the zone. The block either commits the request and pulses an acknowledge, or refuses it and pulses a reject flag. In the refused case storage is left as it was.

Four modes exist. In the plain mode a request writes one to sixteen bytes, wrapping inside its aligned 16-byte page. In the clear-only mode stored bits may only fall from 1 to 0, so the new value is the old value ANDed with the request data. The frozen mode refuses everything. The lock-mask mode splits storage into aligned 8-byte groups. The first byte of each group is a mask: a 0 in bit k, for k from 1 to 7, protects byte k of the group, and a 0 in bit 0 protects the mask itself. The mask can only lose bits, and every request in this mode commits at most one byte.

The zone storage is modelled inside the block as a small flop array that resets to the erased value 0xFF. A combinational read port exposes it so the surrounding logic can fetch stored bytes.

Top module: `pagelock_filter`

## Requirements
- R1: After reset, wrAck and wrRejected are 0 and every storage byte reads 0xFF.
- R2: With reqMode = 2'b00 (plain), the count is reqLen+1. Data byte i (reqData bits [8i+7:8i]) is stored at the address whose upper bits equal those of reqAddr and whose low 4 bits are (reqAddr[3:0]+i) mod 16. Bytes outside those addresses are unchanged, and wrAck pulses.
- R3: With reqMode = 2'b10 (clear-only), the same bytes as in R2 are addressed, each receives old AND new, and wrAck pulses.
- R4: With reqMode = 2'b11 (frozen), wrRejected pulses and no byte changes.
- R5: With reqMode = 2'b01 (lock-mask), only data byte 0 is considered, at reqAddr. reqLen has no effect on any other byte.
- R6: In lock-mask mode, a write to offset k = reqAddr[2:0] in 1..7 commits data byte 0 unchanged if bit k of the group's first byte is 1. If that bit is 0 the write is refused with wrRejected and the byte keeps its value.
- R7: In lock-mask mode, an accepted write to offset 0 stores old AND new, so no bit of the mask byte can rise.
- R8: In lock-mask mode, a write to offset 0 while bit 0 of that byte is 0 is refused with wrRejected and the byte keeps its value.
- R9: Exactly one of wrAck and wrRejected is 1 in the cycle after a cycle with reqValid = 1. Both are 0 after a cycle without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Write request present this cycle |
| reqMode | input | 2 | Zone mode: 00 plain, 01 lock-mask, 10 clear-only, 11 frozen |
| reqAddr | input | 7 | Start byte address in the zone |
| reqLen | input | 4 | Byte count minus one |
| reqData | input | 128 | Request bytes, byte i at bits [8i+7:8i] |
| rdAddr | input | 7 | Read port address |
| rdData | output | 8 | Stored byte at rdAddr |
| wrAck | output | 1 | Pulse: previous request committed |
| wrRejected | output | 1 | Pulse: previous request refused, storage untouched |

## Verification
The checker assumes that reqMode carries one of the four encodings above whenever reqValid is high. It also assumes that a storage byte is compared only while rdAddr stays the same across two edges, because the no-change and no-rising-bit properties compare rdData with its value one edge earlier. The bench drives every request for exactly one cycle with an idle cycle after it and moves rdAddr only on falling edges, so each response lands in its own cycle. Each stored byte is read back through the port after the response has been scored.

// File: rtl/pagelock_pkg.sv
package pagelock_pkg;
  parameter int unsigned LANES = 16;

  typedef enum logic [1:0] {
    MODE_PLAIN  = 2'b00,
    MODE_LOCK   = 2'b01,
    MODE_CLEAR  = 2'b10,
    MODE_FROZEN = 2'b11
  } zoneMode_e;

  typedef struct packed {
    logic [LANES-1:0] laneEn;
    logic             andMerge;
    logic             ack;
    logic             reject;
  } strobe_t;
endpackage

// File: rtl/pagelock_ctrl.sv
module pagelock_ctrl
  import pagelock_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LOCK_SPAN = 8,
  localparam int unsigned LOCK_W   = $clog2(LOCK_SPAN),
  localparam int unsigned PAGE_W   = $clog2(LANES)
) (
  input  logic              reqValid,
  input  zoneMode_e         reqMode,
  input  logic [LOCK_W-1:0] lockOfs,
  input  logic [PAGE_W-1:0] reqLen,
  input  logic [DATA_W-1:0] lockByte,
  output strobe_t           strb
);
  logic [LANES-1:0] lenMask;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lenMask[i] = (PAGE_W + 1)'(i) <= {1'b0, reqLen};
    end
  end

  always_comb begin
    strb = '0;
    if (reqValid) begin
      unique case (reqMode)
        MODE_PLAIN: begin
          strb.laneEn = lenMask;
          strb.ack    = 1'b1;
        end
        MODE_CLEAR: begin
          strb.laneEn   = lenMask;
          strb.andMerge = 1'b1;
          strb.ack      = 1'b1;
        end
        MODE_LOCK: begin
          if (lockByte[lockOfs]) begin
            strb.laneEn   = LANES'(1);
            strb.andMerge = (lockOfs == '0);
            strb.ack      = 1'b1;
          end else begin
            strb.reject = 1'b1;
          end
        end
        default: strb.reject = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/pagelock_dp.sv
module pagelock_dp
  import pagelock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LOCK_SPAN = 8,
  localparam int unsigned DEPTH    = 1 << ADDR_W,
  localparam int unsigned LOCK_W   = $clog2(LOCK_SPAN),
  localparam int unsigned PAGE_W   = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [LANES*DATA_W-1:0] reqData,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [DATA_W-1:0]       rdData,
  output logic [DATA_W-1:0]       lockByte,
  output logic                    wrAck,
  output logic                    wrRejected
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] laneData [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneData[i] = reqData[i*DATA_W +: DATA_W];
  end

  assign lockByte = mem[{reqAddr[ADDR_W-1:LOCK_W], {LOCK_W{1'b0}}}];
  assign rdData   = mem[rdAddr];

  for (genvar j = 0; j < DEPTH; j++) begin : g_cell
    localparam logic [ADDR_W-1:0] CELL = ADDR_W'(j);
    logic              samePage;
    logic              hit;
    logic [PAGE_W-1:0] lane;
    logic [DATA_W-1:0] newVal;

    assign samePage = CELL[ADDR_W-1:PAGE_W] == reqAddr[ADDR_W-1:PAGE_W];
    assign lane     = CELL[PAGE_W-1:0] - reqAddr[PAGE_W-1:0];
    assign hit      = samePage && strb.laneEn[lane];
    assign newVal   = strb.andMerge ? (mem[j] & laneData[lane]) : laneData[lane];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    mem[j] <= '1;
      else if (hit) mem[j] <= newVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAck      <= 1'b0;
      wrRejected <= 1'b0;
    end else begin
      wrAck      <= strb.ack;
      wrRejected <= strb.reject;
    end
  end
endmodule

// File: rtl/pagelock_filter.sv
module pagelock_filter
  import pagelock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LOCK_SPAN = 8,
  localparam int unsigned LOCK_W   = $clog2(LOCK_SPAN),
  localparam int unsigned PAGE_W   = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic [1:0]              reqMode,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [PAGE_W-1:0]       reqLen,
  input  logic [LANES*DATA_W-1:0] reqData,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [DATA_W-1:0]       rdData,
  output logic                    wrAck,
  output logic                    wrRejected
);
  strobe_t           strb;
  logic [DATA_W-1:0] lockByte;

  pagelock_ctrl #(.DATA_W(DATA_W), .LOCK_SPAN(LOCK_SPAN)) ctrl_i (
    .reqValid (reqValid),
    .reqMode  (zoneMode_e'(reqMode)),
    .lockOfs  (reqAddr[LOCK_W-1:0]),
    .reqLen   (reqLen),
    .lockByte (lockByte),
    .strb     (strb)
  );

  pagelock_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_SPAN(LOCK_SPAN)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .lockByte   (lockByte),
    .wrAck      (wrAck),
    .wrRejected (wrRejected)
  );
endmodule

// File: rtl/pagelock_filter_chk.sv
module pagelock_filter_chk #(
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LOCK_SPAN = 8,
  localparam int unsigned LOCK_W   = $clog2(LOCK_SPAN)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        reqMode,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              wrAck,
  input logic              wrRejected
);
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(wrAck && wrRejected)); // R9

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!wrAck && !wrRejected)); // R9

  AST_PLAIN_ACCEPTED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == 2'b00) |=> wrAck); // R2

  AST_CLEAR_ACCEPTED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == 2'b10) |=> wrAck); // R3

  AST_FROZEN_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == 2'b11) |=> (wrRejected && !wrAck)); // R4

  AST_REFUSAL_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (wrRejected && $stable(rdAddr)) |-> $stable(rdData)); // R6

  AST_CLEAR_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqValid && reqMode == 2'b10) && $stable(rdAddr))
      |-> ((rdData & ~$past(rdData)) == '0)); // R3

  AST_MASK_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(reqValid && reqMode == 2'b01 && reqAddr[LOCK_W-1:0] == '0)
      && $stable(rdAddr) && rdAddr == $past(reqAddr))
      |-> ((rdData & ~$past(rdData)) == '0)); // R7
endmodule

bind pagelock_filter pagelock_filter_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_SPAN(LOCK_SPAN)
) chk_i (.*);

// File: tb/pagelock_filter_tb_top.sv
module pagelock_filter_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic [1:0]   reqMode = 2'b00;
  logic [6:0]   reqAddr = '0;
  logic [3:0]   reqLen = '0;
  logic [127:0] reqData = '0;
  logic [6:0]   rdAddr = '0;
  logic [7:0]   rdData;
  logic         wrAck;
  logic         wrRejected;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  model [128];
  logic [1:0]  expQ [$];
  string       tagQ [$];
  logic [127:0] pat;

  always #5 clk = ~clk;

  pagelock_filter dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqData(reqData),
    .rdAddr(rdAddr), .rdData(rdData), .wrAck(wrAck), .wrRejected(wrRejected)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // driver: computes expected outcome from the requirements, then drives
  task automatic doWrite(input logic [1:0] mode, input logic [6:0] addr,
                         input int count, input logic [127:0] data, input string tag);
    logic [1:0] outcome;  // {ack, rejected}
    logic [6:0] base;
    outcome = 2'b00;
    case (mode)
      2'b00, 2'b10: begin
        outcome = 2'b10;
        for (int i = 0; i < count; i++) begin
          logic [6:0] a;
          a = {addr[6:4], 4'(addr[3:0] + i)};
          model[a] = (mode == 2'b10) ? (model[a] & data[8*i +: 8]) : data[8*i +: 8];
        end
      end
      2'b11: outcome = 2'b01;
      default: begin
        base = {addr[6:3], 3'b000};
        if (model[base][addr[2:0]]) begin
          outcome = 2'b10;
          model[addr] = (addr[2:0] == 3'd0) ? (model[addr] & data[7:0]) : data[7:0];
        end else begin
          outcome = 2'b01;
        end
      end
    endcase
    @(negedge clk);
    expQ.push_back(outcome);
    tagQ.push_back(tag);
    reqMode  = mode;
    reqAddr  = addr;
    reqLen   = 4'(count - 1);
    reqData  = data;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic checkByte(input logic [6:0] a, input string tag);
    @(negedge clk);
    rdAddr = a;
    #1;
    check(rdData === model[a], tag, rdData, model[a]);
  endtask

  // monitor: scores each response against the queue
  always @(negedge clk) begin
    if (rstN && (wrAck || wrRejected)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R9 unexpected response", {wrAck, wrRejected}, 0);
      end else begin
        logic [1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({wrAck, wrRejected} === e, t, {wrAck, wrRejected}, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finishRun();
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check(wrAck === 1'b0 && wrRejected === 1'b0, "R1 outputs idle", {wrAck, wrRejected}, 0);
    checkByte(7'h00, "R1 erased byte 0x00");
    checkByte(7'h7F, "R1 erased byte 0x7F");

    // R2 plain writes, single byte, bits may rise
    doWrite(2'b00, 7'h05, 1, 128'h3C, "R2 single byte ack");
    checkByte(7'h05, "R2 single byte value");
    doWrite(2'b00, 7'h05, 1, 128'hA5, "R2 overwrite ack");
    checkByte(7'h05, "R2 overwrite value");

    // R2 full page with wrap
    for (int i = 0; i < 16; i++) pat[8*i +: 8] = 8'h80 + 8'(i);
    doWrite(2'b00, 7'h1A, 16, pat, "R2 page ack");
    for (int i = 0; i < 16; i++) checkByte(7'h10 + 7'(i), "R2 page wrap byte");
    checkByte(7'h20, "R2 next page untouched");
    doWrite(2'b00, 7'h2E, 3, 128'h00_99_88_77, "R2 short wrap ack");
    checkByte(7'h2E, "R2 short wrap first");
    checkByte(7'h2F, "R2 short wrap second");
    checkByte(7'h20, "R2 short wrap third");
    checkByte(7'h21, "R2 short wrap beyond count");
    checkByte(7'h30, "R2 short wrap next page");

    // R3 clear-only
    doWrite(2'b00, 7'h40, 4, 128'hCC_33_F0_0F, "R3 preset ack");
    doWrite(2'b10, 7'h40, 4, 128'h00_55_0F_FF, "R3 clear-only ack");
    for (int i = 0; i < 5; i++) checkByte(7'h40 + 7'(i), "R3 clear-only byte");

    // R4 frozen
    doWrite(2'b11, 7'h05, 4, 128'h0, "R4 frozen rejected");
    checkByte(7'h05, "R4 frozen unchanged");
    checkByte(7'h06, "R4 frozen neighbour unchanged");

    // R5 lock-mask, only first byte
    doWrite(2'b01, 7'h63, 4, 128'h44_33_22_12, "R5 lock-mask ack");
    checkByte(7'h63, "R5 first byte written");
    checkByte(7'h64, "R5 second byte untouched");
    checkByte(7'h65, "R5 third byte untouched");

    // R7 mask byte only loses bits
    doWrite(2'b01, 7'h60, 1, 128'hF7, "R7 mask clear bit3 ack");
    checkByte(7'h60, "R7 mask value F7");
    doWrite(2'b01, 7'h60, 1, 128'hFF, "R7 mask raise attempt ack");
    checkByte(7'h60, "R7 mask bits stay low");

    // R6 protected and open bytes
    doWrite(2'b01, 7'h63, 1, 128'h5A, "R6 protected byte rejected");
    checkByte(7'h63, "R6 protected byte unchanged");
    doWrite(2'b01, 7'h64, 1, 128'h6B, "R6 open byte ack");
    checkByte(7'h64, "R6 open byte written");

    // R8 self-lock
    doWrite(2'b01, 7'h60, 1, 128'hF6, "R8 self-lock ack");
    checkByte(7'h60, "R8 mask value F6");
    doWrite(2'b01, 7'h60, 1, 128'h00, "R8 locked mask rejected");
    checkByte(7'h60, "R8 locked mask unchanged");
    doWrite(2'b01, 7'h61, 1, 128'h11, "R6 byte1 still open ack");
    checkByte(7'h61, "R6 byte1 written");

    // R9 no response without request
    repeat (2) @(negedge clk);
    check(wrAck === 1'b0 && wrRejected === 1'b0, "R9 idle outputs", {wrAck, wrRejected}, 0);
    check(expQ.size() == 0, "R9 all responses seen", expQ.size(), 0);

    done = 1;
    finishRun();
  end
endmodule